// File: doc/BRIEF.md
# Multiplexed CPU Bus Bridge

This block sits between a processor that shares one 32-bit bus for addresses and data and an internal bus that has separate address, write-data and read-data paths. When the processor pulses its address strobe, the bridge captures the upper address bits. The two lowest word-address bits come from dedicated pins that step through the words of a cache-line refill. While the cycle-in-progress line is low, each read or write strobe becomes one request on the internal bus. The bridge answers the processor with a one-cycle active-low acknowledge. Read data is driven back onto the shared bus during that acknowledge.

Accesses that fall in one configurable address window bypass the internal bus. They go to an 8-bit peripheral port that has a chip select, a read strobe and a write strobe. The strobes are held for a fixed number of clocks, and then the processor is acknowledged.

The block also brings the processor out of reset. It holds the cold and warm reset lines low in sequence. During that time it drives fixed configuration values onto the bus-grant pin and the four interrupt pins. It then hands the interrupt pins to two peripheral interrupt sources.

Top module: `cpu_bus_bridge`

## Requirements
- R1: The internal address `ibAddr[31:4]` equals the value on `cpuAdIn[31:4]` at the last clock where `cpuAle` was high. `ibAddr[3:2]` equals `cpuWordIdx` at the clock the access starts. `ibAddr` does not change while `ibReq` is high.
- R2: For a read, the bridge raises `ibReq` with `ibRdN` low and `ibWrN` = 4'hF. Once `ibAck` is sampled high, `cpuAckN` goes low for exactly one cycle. During that cycle `cpuAdOe` is high and `cpuAdOut` carries the `ibDin` value captured with the acknowledge. From strobe to acknowledge this takes 2 + (cycles `ibAck` was withheld) clocks.
- R3: For a write, `ibDout` carries `cpuAdIn` as it was at the start of the access. `ibWrN` equals `cpuBeN` (bit n low means byte lane n is written), `ibRdN` stays high, and `cpuAdOe` stays low.
- R4: While `cpuCipN` stays low and the strobe stays asserted, every acknowledged word is followed by a new internal request. Each new request uses the current `cpuWordIdx`.
- R5: `ibReq` stays high until `ibAck` is sampled high, and then it drops.
- R6: An access whose address matches the window (address AND `PER_MASK` == `PER_BASE`) never raises `ibReq`. `perCsN` and the matching strobe (`perRdN` for reads, `perWrN` for writes) are low for exactly `PER_CYC` (default 4) cycles, and `cpuAckN` goes low in the cycle that follows.
- R7: A peripheral write drives `cpuAdIn[7:0]` onto `perDout` and `cpuWordIdx` onto `perAddr`. A peripheral read returns `{24'h0, perDin}` on `cpuAdOut`.
- R8: After `rst_n` is released, `cpuColdRstN` stays low for `COLD_CYC` (64) clocks and `cpuRstN` for `COLD_CYC + WARM_GAP` (80) clocks. `cpuGntN` = `MODE_GNT` and `cpuIntN` = `MODE_INT` are driven for `COLD_CYC + WARM_GAP + MODE_HOLD` (84) clocks, and also throughout `rst_n`.
- R9: After the mode-bit phase, `cpuIntN[0]` follows `irIrqN`, `cpuIntN[1]` follows `audIrqN`, `cpuIntN[3:2]` are high and `cpuGntN` is high.
- R10: A processor strobe seen while `cpuRstN` is still low is ignored. No `ibReq`, no peripheral strobe and no acknowledge result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cpuAdIn | input | 32 | Shared address/data bus, value from the processor |
| cpuAdOut | output | 32 | Read data driven toward the processor |
| cpuAdOe | output | 1 | Output enable for `cpuAdOut` |
| cpuWordIdx | input | 2 | Word-within-line address pins |
| cpuBeN | input | 4 | Active-low byte-lane enables |
| cpuAle | input | 1 | Address latch strobe, active high |
| cpuCipN | input | 1 | Cycle in progress, active low |
| cpuRdN | input | 1 | Read strobe, active low |
| cpuWrN | input | 1 | Write strobe, active low |
| cpuAckN | output | 1 | Acknowledge to the processor, active low |
| cpuColdRstN | output | 1 | Cold reset to the processor |
| cpuRstN | output | 1 | Warm reset to the processor |
| cpuGntN | output | 1 | Bus grant pin; carries a mode bit during reset |
| cpuIntN | output | 4 | Interrupt pins; carry mode bits during reset |
| irIrqN | input | 1 | Infrared interrupt, active low |
| audIrqN | input | 1 | Audio interrupt, active low |
| ibAddr | output | 30 | Internal bus word address [31:2] |
| ibDout | output | 32 | Internal bus write data |
| ibDin | input | 32 | Internal bus read data |
| ibReq | output | 1 | Internal bus request |
| ibRdN | output | 1 | Internal read strobe, active low |
| ibWrN | output | 4 | Internal per-lane write strobes, active low |
| ibAck | input | 1 | Internal bus acknowledge, active high |
| perCsN | output | 1 | Peripheral chip select, active low |
| perRdN | output | 1 | Peripheral read strobe, active low |
| perWrN | output | 1 | Peripheral write strobe, active low |
| perAddr | output | 2 | Peripheral register select |
| perDout | output | 8 | Peripheral write data |
| perDin | input | 8 | Peripheral read data |

## Verification
The bench builds the bridge with its default parameters: a 64/16/4-clock reset schedule, a 4-clock peripheral strobe and the window at 0x1F000000 under mask 0xFF000000. At these values every edge of the reset sequence can be counted clock by clock in a short run. A strobe can also be placed inside the warm-reset window to show that it is dropped.

The internal-bus responder delays its acknowledge by 0 to 5 cycles. This exposes the latency arithmetic and the request hold. Reads, writes and mixed byte-enable patterns are sent both inside and outside the window, and four-word bursts are run in both directions.

// File: rtl/cbb_pkg.sv
package cbb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IB   = 2'd1,
    ST_PER  = 2'd2,
    ST_ACK  = 2'd3
  } busSt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;     // capture write data, lanes and word index
    logic capIb;     // capture internal read data
    logic capPer;    // capture peripheral read data
    logic ibActive;  // internal request is live
    logic rdCycle;   // current access is a read
  } ctlStrb_t;

endpackage

// File: rtl/cbb_rstseq.sv
module cbb_rstseq #(
  parameter int COLD_CYC  = 64,
  parameter int WARM_GAP  = 16,
  parameter int MODE_HOLD = 4,
  parameter logic       MODE_GNT = 1'b0,
  parameter logic [3:0] MODE_INT = 4'b1001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irIrqN,
  input  logic       audIrqN,
  output logic       cpuColdRstN,
  output logic       cpuRstN,
  output logic       cpuGntN,
  output logic [3:0] cpuIntN,
  output logic       busEn
);
  localparam int WARM_AT = COLD_CYC + WARM_GAP;
  localparam int DONE_AT = WARM_AT + MODE_HOLD;
  localparam int CW      = $clog2(DONE_AT + 1);

  logic [CW-1:0] seqCnt;
  logic          modeDrv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seqCnt <= '0;
    else if (seqCnt != CW'(DONE_AT)) seqCnt <= seqCnt + 1'b1;
  end

  assign cpuColdRstN = (seqCnt >= CW'(COLD_CYC));
  assign cpuRstN     = (seqCnt >= CW'(WARM_AT));
  assign modeDrv     = (seqCnt <  CW'(DONE_AT));
  assign busEn       = cpuRstN;

  assign cpuGntN = modeDrv ? MODE_GNT : 1'b1;
  assign cpuIntN = modeDrv ? MODE_INT : {2'b11, audIrqN, irIrqN};

  AST_COLD_INSIDE_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    !cpuColdRstN |-> !cpuRstN); // R8
  AST_MODE_DURING_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    !cpuRstN |-> (cpuIntN == MODE_INT && cpuGntN == MODE_GNT)); // R8
  AST_COLD_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cpuColdRstN |=> cpuColdRstN); // R8

endmodule

// File: rtl/cbb_ctrl.sv
module cbb_ctrl
  import cbb_pkg::*;
#(
  parameter int PER_CYC = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     busEn,
  input  logic     cpuCipN,
  input  logic     cpuRdN,
  input  logic     cpuWrN,
  input  logic     perHit,
  input  logic     ibAck,
  output logic     ibReq,
  output logic     perCsN,
  output logic     perRdN,
  output logic     perWrN,
  output logic     cpuAckN,
  output logic     cpuAdOe,
  output ctlStrb_t strb
);
  localparam int PW = (PER_CYC > 1) ? $clog2(PER_CYC) : 1;

  busSt_t        st;
  logic [PW-1:0] perCnt;
  logic          rdQ;
  logic          startReq;

  assign startReq = busEn && !cpuCipN && (!cpuRdN || !cpuWrN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      perCnt <= '0;
      rdQ    <= 1'b0;
      ibReq  <= 1'b0;
      perCsN <= 1'b1;
      perRdN <= 1'b1;
      perWrN <= 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: if (startReq) begin
          rdQ <= !cpuRdN;
          if (perHit) begin
            st     <= ST_PER;
            perCnt <= PW'(PER_CYC - 1);
            perCsN <= 1'b0;
            perRdN <= cpuRdN;
            perWrN <= !cpuRdN;
          end else begin
            st    <= ST_IB;
            ibReq <= 1'b1;
          end
        end
        ST_IB: if (ibAck) begin
          ibReq <= 1'b0;
          st    <= ST_ACK;
        end
        ST_PER: begin
          if (perCnt == '0) begin
            perCsN <= 1'b1;
            perRdN <= 1'b1;
            perWrN <= 1'b1;
            st     <= ST_ACK;
          end else begin
            perCnt <= perCnt - 1'b1;
          end
        end
        ST_ACK: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cpuAckN = (st != ST_ACK);
  assign cpuAdOe = (st == ST_ACK) && rdQ;

  always_comb begin
    strb          = '0;
    strb.issue    = (st == ST_IDLE) && startReq;
    strb.capIb    = (st == ST_IB) && ibAck;
    strb.capPer   = (st == ST_PER) && (perCnt == '0);
    strb.ibActive = ibReq;
    strb.rdCycle  = rdQ;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpuAckN |=> cpuAckN); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ibReq && !ibAck) |=> ibReq); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ibReq && ibAck) |=> !ibReq); // R5
  AST_PER_NO_IB: assert property (@(posedge clk) disable iff (!rst_n)
    !perCsN |-> !ibReq); // R6
  AST_PER_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perCsN) |=> !perCsN); // R6
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !busEn |-> (!ibReq && perCsN && cpuAckN)); // R10
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cpuAdOe |-> !cpuAckN); // R3

endmodule

// File: rtl/cbb_dpath.sv
module cbb_dpath
  import cbb_pkg::*;
#(
  parameter logic [31:0] PER_BASE = 32'h1F00_0000,
  parameter logic [31:0] PER_MASK = 32'hFF00_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctlStrb_t    strb,
  input  logic [31:0] cpuAdIn,
  input  logic [1:0]  cpuWordIdx,
  input  logic [3:0]  cpuBeN,
  input  logic        cpuAle,
  input  logic [31:0] ibDin,
  input  logic [7:0]  perDin,
  output logic [31:0] cpuAdOut,
  output logic [31:2] ibAddr,
  output logic [31:0] ibDout,
  output logic        ibRdN,
  output logic [3:0]  ibWrN,
  output logic [1:0]  perAddr,
  output logic [7:0]  perDout,
  output logic        perHit
);
  logic [31:4] addrHi;
  logic [1:0]  wordQ;
  logic [3:0]  beNQ;
  logic [31:0] wdataQ;
  logic [31:0] rdataQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrHi <= '0;
      wordQ  <= '0;
      beNQ   <= '1;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (cpuAle) addrHi <= cpuAdIn[31:4];
      if (strb.issue) begin
        wordQ  <= cpuWordIdx;
        beNQ   <= cpuBeN;
        wdataQ <= cpuAdIn;
      end
      if (strb.capIb)       rdataQ <= ibDin;
      else if (strb.capPer) rdataQ <= {24'h0, perDin};
    end
  end

  assign perHit   = (({addrHi, 4'h0} & PER_MASK) == (PER_BASE & PER_MASK));
  assign ibAddr   = {addrHi, wordQ};
  assign ibDout   = wdataQ;
  assign ibRdN    = !(strb.ibActive && strb.rdCycle);
  assign ibWrN    = (strb.ibActive && !strb.rdCycle) ? beNQ : 4'hF;
  assign cpuAdOut = rdataQ;
  assign perAddr  = wordQ;
  assign perDout  = wdataQ[7:0];

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (ibWrN != 4'hF) |-> ibRdN); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ibActive && $past(strb.ibActive)) |-> $stable(ibAddr)); // R1

endmodule

// File: rtl/cpu_bus_bridge.sv
module cpu_bus_bridge
  import cbb_pkg::*;
#(
  parameter int          COLD_CYC  = 64,
  parameter int          WARM_GAP  = 16,
  parameter int          MODE_HOLD = 4,
  parameter logic        MODE_GNT  = 1'b0,
  parameter logic [3:0]  MODE_INT  = 4'b1001,
  parameter int          PER_CYC   = 4,
  parameter logic [31:0] PER_BASE  = 32'h1F00_0000,
  parameter logic [31:0] PER_MASK  = 32'hFF00_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cpuAdIn,
  output logic [31:0] cpuAdOut,
  output logic        cpuAdOe,
  input  logic [1:0]  cpuWordIdx,
  input  logic [3:0]  cpuBeN,
  input  logic        cpuAle,
  input  logic        cpuCipN,
  input  logic        cpuRdN,
  input  logic        cpuWrN,
  output logic        cpuAckN,
  output logic        cpuColdRstN,
  output logic        cpuRstN,
  output logic        cpuGntN,
  output logic [3:0]  cpuIntN,
  input  logic        irIrqN,
  input  logic        audIrqN,
  output logic [31:2] ibAddr,
  output logic [31:0] ibDout,
  input  logic [31:0] ibDin,
  output logic        ibReq,
  output logic        ibRdN,
  output logic [3:0]  ibWrN,
  input  logic        ibAck,
  output logic        perCsN,
  output logic        perRdN,
  output logic        perWrN,
  output logic [1:0]  perAddr,
  output logic [7:0]  perDout,
  input  logic [7:0]  perDin
);
  ctlStrb_t strb;
  logic     busEn;
  logic     perHit;

  cbb_rstseq #(
    .COLD_CYC(COLD_CYC), .WARM_GAP(WARM_GAP), .MODE_HOLD(MODE_HOLD),
    .MODE_GNT(MODE_GNT), .MODE_INT(MODE_INT)
  ) u_rstseq (
    .clk(clk), .rst_n(rst_n), .irIrqN(irIrqN), .audIrqN(audIrqN),
    .cpuColdRstN(cpuColdRstN), .cpuRstN(cpuRstN), .cpuGntN(cpuGntN),
    .cpuIntN(cpuIntN), .busEn(busEn)
  );

  cbb_ctrl #(.PER_CYC(PER_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busEn(busEn), .cpuCipN(cpuCipN),
    .cpuRdN(cpuRdN), .cpuWrN(cpuWrN), .perHit(perHit), .ibAck(ibAck),
    .ibReq(ibReq), .perCsN(perCsN), .perRdN(perRdN), .perWrN(perWrN),
    .cpuAckN(cpuAckN), .cpuAdOe(cpuAdOe), .strb(strb)
  );

  cbb_dpath #(.PER_BASE(PER_BASE), .PER_MASK(PER_MASK)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cpuAdIn(cpuAdIn),
    .cpuWordIdx(cpuWordIdx), .cpuBeN(cpuBeN), .cpuAle(cpuAle),
    .ibDin(ibDin), .perDin(perDin), .cpuAdOut(cpuAdOut), .ibAddr(ibAddr),
    .ibDout(ibDout), .ibRdN(ibRdN), .ibWrN(ibWrN), .perAddr(perAddr),
    .perDout(perDout), .perHit(perHit)
  );

endmodule

// File: tb/cpu_bus_bridge_bench.sv
`timescale 1ns/1ps
module cpu_bus_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpuAdIn = '0;
  logic [31:0] cpuAdOut;
  logic        cpuAdOe;
  logic [1:0]  cpuWordIdx = '0;
  logic [3:0]  cpuBeN = 4'hF;
  logic        cpuAle = 1'b0, cpuCipN = 1'b1, cpuRdN = 1'b1, cpuWrN = 1'b1;
  logic        cpuAckN, cpuColdRstN, cpuRstN, cpuGntN;
  logic [3:0]  cpuIntN;
  logic        irIrqN = 1'b1, audIrqN = 1'b1;
  logic [31:2] ibAddr;
  logic [31:0] ibDout;
  logic [31:0] ibDin = '0;
  logic        ibReq, ibRdN;
  logic [3:0]  ibWrN;
  logic        ibAck = 1'b0;
  logic        perCsN, perRdN, perWrN;
  logic [1:0]  perAddr;
  logic [7:0]  perDout;
  logic [7:0]  perDin = 8'h00;

  always #5 clk = ~clk;

  cpu_bus_bridge u_cpu_bus_bridge (.*);

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // internal bus responder
  int          respLat = 0;
  logic [31:0] respData = '0;
  int          waitCnt = 0;
  bit          inReq = 1'b0;
  int          reqCount = 0;
  logic [31:2] seenAddr;
  logic [31:0] seenDout;
  logic        seenRdN;
  logic [3:0]  seenWrN;

  always @(negedge clk) begin
    if (ibAck) ibAck = 1'b0;
    else if (ibReq) begin
      if (!inReq) begin
        inReq = 1'b1; waitCnt = 0; reqCount++;
        seenAddr = ibAddr; seenDout = ibDout; seenRdN = ibRdN; seenWrN = ibWrN;
      end
      if (waitCnt == respLat) begin
        ibAck = 1'b1;
        ibDin = respData ^ {30'h0, ibAddr[3:2]};
      end else waitCnt++;
    end
    if (!ibReq) inReq = 1'b0;
  end

  typedef struct packed {
    logic        rd;
    logic [1:0]  word;
    logic [3:0]  be;
    logic [3:0]  lat;
    logic [31:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 4'h0, 4'd0, 32'h0000_1230, 32'hDEAD_BEEF},
    '{1'b1, 2'd3, 4'h0, 4'd3, 32'h8000_0040, 32'h1234_5678},
    '{1'b0, 2'd1, 4'h0, 4'd0, 32'h0000_2000, 32'hCAFE_F00D},
    '{1'b0, 2'd2, 4'hE, 4'd2, 32'h4000_0010, 32'h0000_00A5},
    '{1'b0, 2'd0, 4'h3, 4'd5, 32'h2F00_0100, 32'hA1B2_C3D4},
    '{1'b1, 2'd2, 4'h0, 4'd1, 32'h1E00_0000, 32'h0F0F_0F0F}
  };

  task automatic startAccess(input logic rd, input logic [31:0] addr, input logic [1:0] word,
                             input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    cpuAle = 1'b1; cpuAdIn = addr; cpuCipN = 1'b0;
    @(negedge clk);
    cpuAle = 1'b0; cpuWordIdx = word; cpuBeN = be;
    cpuAdIn = rd ? 32'h0 : wd;
    if (rd) cpuRdN = 1'b0; else cpuWrN = 1'b0;
  endtask

  task automatic endAccess();
    cpuCipN = 1'b1; cpuRdN = 1'b1; cpuWrN = 1'b1; cpuBeN = 4'hF;
  endtask

  task automatic waitAck(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (cpuAckN && n < 60);
  endtask

  task automatic ibXfer(input vec_t v);
    int n;
    respLat = v.lat; respData = v.data;
    startAccess(v.rd, v.addr, v.word, v.be, v.data);
    waitAck(n);
    chk(n == v.lat + 2, "R2 ack latency", n, v.lat + 2);
    chk(seenAddr == {v.addr[31:4], v.word}, "R1 latched address", {seenAddr, 2'b00}, {v.addr[31:4], v.word, 2'b00});
    if (v.rd) begin
      chk(cpuAdOe && cpuAdOut == (v.data ^ {30'h0, v.word}), "R2 read data", cpuAdOut, v.data ^ {30'h0, v.word});
      chk(!seenRdN && seenWrN == 4'hF, "R2 read strobes", {seenRdN, seenWrN}, 5'h0F);
    end else begin
      chk(seenDout == v.data, "R3 write data", seenDout, v.data);
      chk(seenWrN == v.be && seenRdN, "R3 lane strobes", {seenRdN, seenWrN}, {1'b1, v.be});
      chk(!cpuAdOe, "R3 no drive on write", cpuAdOe, 0);
    end
    endAccess();
    @(negedge clk);
    chk(cpuAckN, "R2 ack one cycle", cpuAckN, 1);
  endtask

  task automatic perXfer(input logic rd, input logic [1:0] word, input logic [31:0] wd, input logic [7:0] pd);
    int n, lowCnt, r0;
    bit strobeOk;
    r0 = reqCount; perDin = pd; lowCnt = 0; strobeOk = 1'b1;
    startAccess(rd, 32'h1F00_0040, word, 4'h0, wd);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!perCsN) begin
        lowCnt++;
        if (rd ? (perRdN || !perWrN) : (perWrN || !perRdN)) strobeOk = 1'b0;
        if (!rd && (perDout != wd[7:0] || perAddr != word)) strobeOk = 1'b0;
      end
    end while (cpuAckN && n < 60);
    chk(lowCnt == 4, "R6 strobe width", lowCnt, 4);
    chk(n == 5, "R6 ack after strobe", n, 5);
    chk(reqCount == r0, "R6 no internal request", reqCount, r0);
    chk(strobeOk, rd ? "R6 read strobe" : "R7 write data and select", strobeOk, 1);
    if (rd) chk(cpuAdOut == {24'h0, pd} && cpuAdOe, "R7 read byte", cpuAdOut, {24'h0, pd});
    endAccess();
    @(negedge clk);
  endtask

  task automatic burst(input logic rd, input logic [31:0] base, input logic [31:0] dat);
    int n, r0;
    r0 = reqCount; respLat = 1; respData = dat;
    startAccess(rd, base, 2'd0, 4'h0, dat);
    for (int w = 0; w < 4; w++) begin
      waitAck(n);
      chk(seenAddr[3:2] == 2'(w), "R4 burst word index", seenAddr[3:2], w);
      if (rd) chk(cpuAdOut == (dat ^ 32'(w)), "R4 burst read data", cpuAdOut, dat ^ 32'(w));
      else    chk(seenDout == dat + 32'(w), "R4 burst write data", seenDout, dat + 32'(w));
      if (w == 3) endAccess();
      else begin cpuWordIdx = 2'(w + 1); cpuAdIn = rd ? 32'h0 : dat + 32'(w + 1); end
    end
    @(negedge clk);
    chk(reqCount == r0 + 4, "R4 one request per word", reqCount, r0 + 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cpuColdRstN && !cpuRstN, "R8 resets low in reset", {cpuColdRstN, cpuRstN}, 0);
    chk(cpuGntN == 1'b0 && cpuIntN == 4'b1001, "R8 mode bits in reset", {cpuGntN, cpuIntN}, 5'b01001);
    chk(!ibReq && cpuAckN && perCsN, "R10 idle in reset", {ibReq, cpuAckN, perCsN}, 3'b011);
    rst_n = 1'b1;
    for (int k = 1; k <= 90; k++) begin
      @(negedge clk);
      if (k == 63) chk(!cpuColdRstN, "R8 cold held", cpuColdRstN, 0);
      if (k == 64) chk(cpuColdRstN && !cpuRstN, "R8 cold release", {cpuColdRstN, cpuRstN}, 2'b10);
      if (k == 70) begin cpuCipN = 1'b0; cpuRdN = 1'b0; end
      if (k == 76) begin
        chk(!ibReq && perCsN && cpuAckN && reqCount == 0, "R10 strobe ignored", {ibReq, perCsN, cpuAckN}, 3'b011);
        endAccess();
      end
      if (k == 79) chk(!cpuRstN, "R8 warm held", cpuRstN, 0);
      if (k == 80) chk(cpuRstN && cpuIntN == 4'b1001, "R8 warm release", {cpuRstN, cpuIntN}, 5'b11001);
      if (k == 83) chk(cpuGntN == 1'b0 && cpuIntN == 4'b1001, "R8 mode bits held", {cpuGntN, cpuIntN}, 5'b01001);
      if (k == 84) chk(cpuGntN && cpuIntN == 4'b1111, "R9 handover", {cpuGntN, cpuIntN}, 5'b11111);
      if (k == 85) irIrqN = 1'b0;
      if (k == 86) begin
        chk(cpuIntN == 4'b1110, "R9 infrared irq", cpuIntN, 4'b1110);
        irIrqN = 1'b1; audIrqN = 1'b0;
      end
      if (k == 87) begin
        chk(cpuIntN == 4'b1101, "R9 audio irq", cpuIntN, 4'b1101);
        audIrqN = 1'b1;
      end
    end
    for (int i = 0; i < NV; i++) ibXfer(VEC[i]);
    burst(1'b1, 32'h0000_8000, 32'h5555_0000);
    burst(1'b0, 32'h0000_9000, 32'h7700_0010);
    perXfer(1'b0, 2'd2, 32'h0000_003C, 8'h00);
    perXfer(1'b1, 2'd1, 32'h0, 8'hC3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired (R2 hang) actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule